// File: doc/BRIEF.md
# Cycle Slip Reduction Current Controller

This block decides how many extra constant-current charge pump cells are switched on while a phase-locked loop acquires a new frequency. The cells widen the linear range of the phase detector, so a narrow loop can lock quickly without slipping cycles. An external detector raises `slip_warn` one phase-detector cycle at a time whenever a cycle slip is about to happen. It also supplies `slip_up`, which tells whether the tuning voltage has to rise or fall. Each such warning adds one cell, up to a ceiling. Once `overshoot` reports that the VCO has passed the target frequency, the block removes the cells one per cycle until none are left.

The function is allowed to run only while `csr_en` is set and the phase detector polarity is positive (`pol_pos` high). If either condition is lost, the cell count drops to zero at the next edge. All inputs are plain control levels sampled on the phase-detector clock. There is no streaming data, so no valid/ready handshake is used. The cells give a steady current, so the outputs are registered levels that change only at a clock edge.

Top module: `csr_ctrl`

## Requirements
- R1: After reset, `cell_cnt` is 0 and `cell_src` is 0.
- R2: While qualified (`csr_en`=1 and `pol_pos`=1), when a cell count below 7 is not ramping down, each cycle with `slip_warn`=1 and `overshoot`=0 raises `cell_cnt` by exactly one at the next edge.
- R3: `cell_cnt` never exceeds 7. A slip warning at a count of 7 leaves the count at 7.
- R4: `cell_src` takes the value of `slip_up` at the warning that switches on the first cell (1 = source current to raise the tuning voltage, 0 = sink). It keeps that value, whatever `slip_up` does, until the count returns to 0.
- R5: Once `overshoot`=1 is seen with at least one cell on, the count falls by exactly one per cycle until it reaches 0. Slip warnings and `overshoot` are ignored during this descent.
- R6: With `csr_en`=0, `cell_cnt` is 0 at the next edge and stays 0, whatever the slip warnings do.
- R7: With `pol_pos`=0 (negative polarity), `cell_cnt` is 0 at the next edge and stays 0, even with `csr_en`=1.
- R8: `overshoot` while no cell is on has no effect, and `cell_src` is 0 whenever `cell_cnt` is 0.
- R9: When `slip_warn` and `overshoot` are high in the same cycle with cells on, the overshoot wins and the count falls by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Phase-detector clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_en | input | 1 | Enable for slip reduction |
| pol_pos | input | 1 | 1 = positive phase detector polarity |
| slip_warn | input | 1 | Cycle slip imminent in this cycle |
| slip_up | input | 1 | Tuning voltage must rise (1) or fall (0) |
| overshoot | input | 1 | VCO frequency has passed the target |
| cell_cnt | output | 3 | Number of active extra current cells |
| cell_src | output | 1 | 1 = cells source current, 0 = cells sink |

## Verification
Every output is a register that updates one edge after the input that causes it. The bench changes the inputs on a falling edge and reads the outputs 1 ns after the following rising edge, so each check sees exactly one step of the block. The sweeps then count expected cell numbers edge by edge: min(n,7) after n warnings, and one fewer per edge during the descent. Disable and polarity checks read the count at the first edge after the change and again on the following edges while warnings continue.

// File: rtl/csr_pkg.sv
package csr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_UP   = 2'd1,
    ST_DOWN = 2'd2
  } csr_state_e;
endpackage

// File: rtl/csr_gate.sv
module csr_gate (
  input  logic csr_en,
  input  logic pol_pos,
  output logic active
);
  // The function may only run with positive polarity and enable set
  assign active = csr_en & pol_pos;
endmodule

// File: rtl/csr_seq.sv
module csr_seq
  import csr_pkg::*;
#(
  parameter int MAX_CELLS = 7,
  localparam int CNT_W = $clog2(MAX_CELLS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic             slip_warn,
  input  logic             overshoot,
  input  logic [CNT_W-1:0] cnt,
  output logic             inc,
  output logic             dec,
  output logic             clr,
  output csr_state_e       state
);
  csr_state_e state_d;
  logic       last_cell;
  logic       full;

  assign last_cell = (cnt == CNT_W'(1));
  assign full      = (cnt == CNT_W'(MAX_CELLS));

  always_comb begin
    state_d = state;
    inc     = 1'b0;
    dec     = 1'b0;
    clr     = 1'b0;
    if (!active) begin
      clr     = 1'b1;
      state_d = ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (slip_warn) begin
            inc     = 1'b1;
            state_d = ST_UP;
          end
        end
        ST_UP: begin
          if (overshoot) begin
            dec     = 1'b1;
            state_d = last_cell ? ST_IDLE : ST_DOWN;
          end else if (slip_warn && !full) begin
            inc = 1'b1;
          end
        end
        ST_DOWN: begin
          dec     = 1'b1;
          state_d = last_cell ? ST_IDLE : ST_DOWN;
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_d;
  end

  AST_ONE_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({inc, dec, clr}) <= 1) else $error("command clash"); // R9
endmodule

// File: rtl/csr_cells.sv
module csr_cells #(
  parameter int MAX_CELLS = 7,
  localparam int CNT_W = $clog2(MAX_CELLS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             dec,
  input  logic             clr,
  input  logic             slip_up,
  output logic [CNT_W-1:0] cnt,
  output logic             src
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      src <= 1'b0;
    end else if (clr) begin
      cnt <= '0;
      src <= 1'b0;
    end else if (inc) begin
      cnt <= cnt + 1'b1;
      if (cnt == '0) src <= slip_up;
    end else if (dec) begin
      cnt <= cnt - 1'b1;
      if (cnt == CNT_W'(1)) src <= 1'b0;
    end
  end

  AST_CNT_CEIL: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(MAX_CELLS)) else $error("count over ceiling"); // R3
  AST_SRC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != '0) |=> (cnt == '0 || $stable(src))) else $error("direction moved"); // R4
  AST_SRC_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0) |-> !src) else $error("direction set with no cells"); // R8
endmodule

// File: rtl/csr_ctrl.sv
module csr_ctrl
  import csr_pkg::*;
#(
  parameter int MAX_CELLS = 7,
  localparam int CNT_W = $clog2(MAX_CELLS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             csr_en,
  input  logic             pol_pos,
  input  logic             slip_warn,
  input  logic             slip_up,
  input  logic             overshoot,
  output logic [CNT_W-1:0] cell_cnt,
  output logic             cell_src
);
  logic       active;
  logic       inc, dec, clr;
  csr_state_e state;

  csr_gate u_gate (
    .csr_en (csr_en),
    .pol_pos(pol_pos),
    .active (active)
  );

  csr_seq #(.MAX_CELLS(MAX_CELLS)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .active   (active),
    .slip_warn(slip_warn),
    .overshoot(overshoot),
    .cnt      (cell_cnt),
    .inc      (inc),
    .dec      (dec),
    .clr      (clr),
    .state    (state)
  );

  csr_cells #(.MAX_CELLS(MAX_CELLS)) u_cells (
    .clk    (clk),
    .rst_n  (rst_n),
    .inc    (inc),
    .dec    (dec),
    .clr    (clr),
    .slip_up(slip_up),
    .cnt    (cell_cnt),
    .src    (cell_src)
  );

  AST_OFF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (cell_cnt == '0)) else $error("count kept while off"); // R6 R7
  AST_DOWN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DOWN && active) |=> (cell_cnt == $past(cell_cnt) - 1'b1))
    else $error("descent not one per cycle"); // R5
  AST_IDLE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> (cell_cnt == '0)) else $error("cells on in idle"); // R8
endmodule

// File: tb/csr_ctrl_bench.sv
module csr_ctrl_bench;
  localparam int MAXC = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic csr_en = 1'b0, pol_pos = 1'b0, slip_warn = 1'b0, slip_up = 1'b0, overshoot = 1'b0;
  logic [2:0] cell_cnt;
  logic cell_src;
  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  csr_ctrl u_csr_ctrl (
    .clk(clk), .rst_n(rst_n), .csr_en(csr_en), .pol_pos(pol_pos),
    .slip_warn(slip_warn), .slip_up(slip_up), .overshoot(overshoot),
    .cell_cnt(cell_cnt), .cell_src(cell_src)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input logic en, input logic pol, input logic w,
                      input logic up, input logic ov);
    @(negedge clk);
    csr_en = en; pol_pos = pol; slip_warn = w; slip_up = up; overshoot = ov;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #1ms;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 count", int'(cell_cnt), 0);
    chk("R1 src", int'(cell_src), 0);
    rst_n = 1'b1;

    // Sweep number of warnings and direction
    for (int d = 0; d < 2; d++) begin
      for (int n = 0; n <= 9; n++) begin
        int c;
        step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        chk("R6 cleared", int'(cell_cnt), 0);
        for (int i = 1; i <= n; i++) begin
          // first warning carries direction d, later ones the opposite
          step(1'b1, 1'b1, 1'b1, (i == 1) ? d[0] : ~d[0], 1'b0);
          chk((i > MAXC) ? "R3 saturate" : "R2 add", int'(cell_cnt), (i < MAXC) ? i : MAXC);
          chk("R4 dir latched", int'(cell_src), d);
        end
        c = (n < MAXC) ? n : MAXC;
        if (n == 0) begin
          step(1'b1, 1'b1, 1'b0, 1'b1, 1'b1);
          chk("R8 overshoot idle", int'(cell_cnt), 0);
          chk("R8 src idle", int'(cell_src), 0);
        end else begin
          // overshoot together with a warning: overshoot wins
          step(1'b1, 1'b1, 1'b1, ~d[0], 1'b1);
          c = c - 1;
          chk("R9 priority", int'(cell_cnt), c);
          while (c > 0) begin
            step(1'b1, 1'b1, 1'b1, ~d[0], 1'b0);
            c = c - 1;
            chk("R5 descent", int'(cell_cnt), c);
            chk("R4 src hold/R8", int'(cell_src), (c > 0) ? d : 0);
          end
          step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
          chk("R5 stays zero", int'(cell_cnt), 0);
          chk("R8 src zero", int'(cell_src), 0);
        end
      end
    end

    // Enable dropped mid-build
    for (int i = 0; i < 5; i++) step(1'b1, 1'b1, 1'b1, 1'b1, 1'b0);
    chk("R2 build", int'(cell_cnt), 5);
    step(1'b0, 1'b1, 1'b1, 1'b1, 1'b0);
    chk("R6 disable", int'(cell_cnt), 0);
    for (int i = 0; i < 3; i++) begin
      step(1'b0, 1'b1, 1'b1, 1'b1, 1'b0);
      chk("R6 ignored", int'(cell_cnt), 0);
    end

    // Negative polarity
    for (int i = 0; i < 4; i++) step(1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
    chk("R2 build", int'(cell_cnt), 4);
    step(1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
    chk("R7 neg polarity", int'(cell_cnt), 0);
    for (int i = 0; i < 3; i++) begin
      step(1'b1, 1'b0, 1'b1, 1'b1, 1'b0);
      chk("R7 ignored", int'(cell_cnt), 0);
      chk("R7 src", int'(cell_src), 0);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule